// File: doc/BRIEF.md
# Challenge-Response Authentication Sequencer

This block sits between a small register bus and a hash engine that is outside it. It manages a challenge-response exchange. The host first writes a selection register that names two of three stored 32-bit keys: one defines the hash function and the other supplies the starting seed. The same key may fill both roles. A valid selection pulses a reload strobe so that the engine takes fresh seeds. The host then writes a 32-bit challenge. The block starts the engine and waits out a fixed settling period of `BTD_CYCLES` clocks, plus any extra time the engine needs. It then latches the 8-bit response, which the host reads back.

A challenge counts only once per selection. A challenge that is not preceded by a new selection is refused. So is a selection with an out-of-range index, and so is a selection made while a hash is running. Each of these raises a sticky error flag. The host clears that flag by writing 1 to it. Per-key lock bits can only be set, never cleared. After a key is locked, the bus can neither read nor change it, but the engine still receives its value.

The sequencer has three states. ST_UNARMED is the reset state and the state after each result. ST_ARMED means a valid selection is held. ST_HASHING means a challenge is being processed. The transitions are:
- T_SELECT: ST_UNARMED or ST_ARMED goes to ST_ARMED on a valid selection write.
- T_LAUNCH: ST_ARMED goes to ST_HASHING on a challenge write.
- T_FINISH: ST_HASHING goes to ST_UNARMED once the settling count has expired and the engine reports done.
- T_REJECT: a refused access leaves the state unchanged and only raises the error flag.

Top module: `auth_ctrl`

## Requirements
- R1: After reset, every register reads zero: lock (address 0), selection (address 4), response (address 6) and status (address 7). The engine strobes are low.
- R2: Key slots 0, 1 and 2 sit at addresses 1, 2 and 3. While a slot is unlocked, the bus can write it and read it back.
- R3: Writing the lock register (address 0) sets each lock bit whose matching data bit (bit 0 for slot 0 up to bit 2 for slot 2) is 1. Lock bits never clear, including when 0 is written to them.
- R4: A bus read or write of a locked slot is refused. A refused read returns zero, a refused write leaves the key unchanged, and either one sets the error flag.
- R5: A locked key is still delivered to the engine, and the response computed from it is correct.
- R6: A selection write (address 4) with function index in bits [1:0] and seed index in bits [3:2], both below 3, does three things. It pulses hash_seed_load for exactly the one cycle after the write edge. It presents the chosen keys on hash_func_key and hash_seed_key. It arms the block. Both indices may be equal.
- R7: A selection write with either index equal to 3 is refused. It sets the error flag and does not arm the block.
- R8: A challenge write (address 5) while armed pulses hash_start for the one cycle after the write edge, presents the challenge on hash_chal, and sets busy (status bit 1).
- R9: The response register (address 6) takes the engine code BTD_CYCLES edges after the challenge write edge, provided hash_done is high. At that point busy clears and valid (status bit 2) sets. Before then, the register still holds the previous response and valid is 0.
- R10: If hash_done is low when the settling count expires, the block keeps waiting. It latches the code on the first edge at which hash_done is high.
- R11: A challenge written when no selection write has occurred since the last challenge is refused. It sets the error flag, produces no hash_start, and leaves the response unchanged.
- R12: The error flag (status bit 0) stays set until the host writes 1 to status bit 0. Writing 0 there has no effect.
- R13: A selection write while busy is refused. It sets the error flag, produces no seed reload, and leaves the selection register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; used only to detect refused key reads |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| hash_seed_load | output | 1 | One-cycle strobe telling the engine to reload its seeds |
| hash_func_key | output | 32 | Key that defines the hash function |
| hash_seed_key | output | 32 | Key that supplies the starting seed |
| hash_start | output | 1 | One-cycle strobe that starts a hash |
| hash_chal | output | 32 | Challenge word for the engine |
| hash_done | input | 1 | Engine result ready |
| hash_code | input | 8 | Engine 8-bit result |

## Verification
A selection or challenge write takes effect on the clock edge where the strobe is high. hash_seed_load, hash_start and busy are therefore due in the half cycle that follows, and the bench samples them at the next falling edge. The response is due exactly BTD_CYCLES edges after the challenge edge. The bench therefore checks that the old response and a clear valid bit are still present half a cycle before that edge, and that the new response is present half a cycle after it. When hash_done is held low, the bench checks that valid stays clear well past the settling count, then raises hash_done and expects the result one edge later. Refusals are detected at the falling edge after the offending access, through the status register. Register contents are read at mid-cycle through the combinational read path, without a read strobe, so these reads have no side effects.

// File: rtl/auth_pkg.sv
package auth_pkg;
    localparam int KEY_W     = 32;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 3;
    localparam int NUM_SLOTS = 3;
    localparam int IDX_W     = 2;
    localparam int CODE_W    = 8;

    localparam int STAT_ERR      = 0;
    localparam int STAT_BUSY     = 1;
    localparam int STAT_VALID    = 2;
    localparam int STAT_ARMED    = 3;
    localparam int STAT_LOCK_LSB = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_LOCK = 3'd0,
        REG_KEY0 = 3'd1,
        REG_KEY1 = 3'd2,
        REG_KEY2 = 3'd3,
        REG_SEL  = 3'd4,
        REG_CHAL = 3'd5,
        REG_CODE = 3'd6,
        REG_STAT = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_UNARMED = 2'd0,
        ST_ARMED   = 2'd1,
        ST_HASHING = 2'd2
    } seq_state_e;
endpackage

// File: rtl/auth_key_store.sv
module auth_key_store
    import auth_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [IDX_W-1:0]                   wr_slot,
    input  logic [KEY_W-1:0]                   wr_data,
    input  logic [NUM_SLOTS-1:0]               lock_set,
    input  logic                               sel_load,
    input  logic [IDX_W-1:0]                   sel_func,
    input  logic [IDX_W-1:0]                   sel_seed,
    output logic [NUM_SLOTS-1:0][KEY_W-1:0]    slot_q,
    output logic [NUM_SLOTS-1:0]               lock_q,
    output logic [IDX_W-1:0]                   func_idx_q,
    output logic [IDX_W-1:0]                   seed_idx_q,
    output logic [KEY_W-1:0]                   func_key,
    output logic [KEY_W-1:0]                   seed_key
);
    // One key register and one lock bit per slot.
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
                lock_q[i] <= 1'b0;
            end else begin
                if (wr_en && (wr_slot == IDX_W'(i)) && !lock_q[i]) begin
                    slot_q[i] <= wr_data;
                end
                lock_q[i] <= lock_q[i] | lock_set[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            func_idx_q <= '0;
            seed_idx_q <= '0;
        end else if (sel_load) begin
            func_idx_q <= sel_func;
            seed_idx_q <= sel_seed;
        end
    end

    // Internal path to the engine: it ignores the lock bits.
    always_comb begin
        func_key = '0;
        seed_key = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (func_idx_q == IDX_W'(i)) func_key = slot_q[i];
            if (seed_idx_q == IDX_W'(i)) seed_key = slot_q[i];
        end
    end
endmodule

// File: rtl/auth_bus_decode.sv
module auth_bus_decode
    import auth_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               bus_wr,
    input  logic                               bus_rd,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  logic [DATA_W-1:0]                  bus_wdata,
    input  logic [NUM_SLOTS-1:0]               lock_q,
    input  logic [NUM_SLOTS-1:0][KEY_W-1:0]    slot_q,
    input  logic [IDX_W-1:0]                   func_idx_q,
    input  logic [IDX_W-1:0]                   seed_idx_q,
    input  logic                               armed,
    input  logic                               busy,
    input  logic                               code_valid,
    input  logic [CODE_W-1:0]                  code_q,
    output logic                               key_wr_en,
    output logic [IDX_W-1:0]                   key_wr_slot,
    output logic [NUM_SLOTS-1:0]               lock_set,
    output logic                               sel_load,
    output logic [IDX_W-1:0]                   sel_func,
    output logic [IDX_W-1:0]                   sel_seed,
    output logic                               chal_load,
    output logic                               err_q,
    output logic [DATA_W-1:0]                  bus_rdata
);
    reg_addr_e           addr_e;
    logic                is_key;
    logic [IDX_W-1:0]    key_idx;
    logic                key_locked;
    logic [KEY_W-1:0]    key_val;
    logic                wr_sel;
    logic                wr_chal;
    logic                sel_ok;
    logic                err_evt;
    logic                err_clr;
    logic [DATA_W-1:0]   stat_word;

    assign addr_e = reg_addr_e'(bus_addr);

    always_comb begin
        is_key     = (addr_e == REG_KEY0) || (addr_e == REG_KEY1) || (addr_e == REG_KEY2);
        key_idx    = IDX_W'(bus_addr - ADDR_W'(1));
        key_locked = 1'b0;
        key_val    = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (key_idx == IDX_W'(i)) begin
                key_locked = lock_q[i];
                key_val    = slot_q[i];
            end
        end
    end

    always_comb begin
        sel_func    = bus_wdata[IDX_W-1:0];
        sel_seed    = bus_wdata[2*IDX_W-1:IDX_W];
        wr_sel      = bus_wr && (addr_e == REG_SEL);
        wr_chal     = bus_wr && (addr_e == REG_CHAL);
        sel_ok      = (sel_func < IDX_W'(NUM_SLOTS)) && (sel_seed < IDX_W'(NUM_SLOTS)) && !busy;
        sel_load    = wr_sel && sel_ok;
        chal_load   = wr_chal && armed;
        key_wr_en   = bus_wr && is_key && !key_locked;
        key_wr_slot = key_idx;
        lock_set    = (bus_wr && (addr_e == REG_LOCK)) ? bus_wdata[NUM_SLOTS-1:0] : '0;
        err_evt     = (is_key && key_locked && (bus_wr || bus_rd))
                    || (wr_sel && !sel_ok)
                    || (wr_chal && !armed);
        err_clr     = bus_wr && (addr_e == REG_STAT) && bus_wdata[STAT_ERR];
    end

    // Sticky error flag; a new refusal has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (err_evt) begin
            err_q <= 1'b1;
        end else if (err_clr) begin
            err_q <= 1'b0;
        end
    end

    always_comb begin
        stat_word                                 = '0;
        stat_word[STAT_ERR]                       = err_q;
        stat_word[STAT_BUSY]                      = busy;
        stat_word[STAT_VALID]                     = code_valid;
        stat_word[STAT_ARMED]                     = armed;
        stat_word[STAT_LOCK_LSB +: NUM_SLOTS]     = lock_q;
    end

    always_comb begin
        unique case (addr_e)
            REG_LOCK:                     bus_rdata = DATA_W'(lock_q);
            REG_KEY0, REG_KEY1, REG_KEY2: bus_rdata = key_locked ? '0 : DATA_W'(key_val);
            REG_SEL:                      bus_rdata = DATA_W'({seed_idx_q, func_idx_q});
            REG_CHAL:                     bus_rdata = '0;
            REG_CODE:                     bus_rdata = DATA_W'(code_q);
            REG_STAT:                     bus_rdata = stat_word;
            default:                      bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/auth_seq_fsm.sv
module auth_seq_fsm
    import auth_pkg::*;
#(
    parameter int BTD_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_load,
    input  logic               chal_load,
    input  logic [KEY_W-1:0]   chal_data,
    input  logic               hash_done,
    input  logic [CODE_W-1:0]  hash_code,
    output logic               armed,
    output logic               busy,
    output logic               hash_seed_load,
    output logic               hash_start,
    output logic [KEY_W-1:0]   hash_chal,
    output logic [CODE_W-1:0]  code_q,
    output logic               code_valid
);
    localparam int CNT_W = $clog2(BTD_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BTD_CYCLES - 1);

    seq_state_e        state_q;
    seq_state_e        state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              launch;
    logic              finish;

    always_comb begin
        launch = chal_load && (state_q == ST_ARMED);
        finish = (state_q == ST_HASHING) && (cnt_q == '0) && hash_done;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_UNARMED;
        else        state_q <= state_d;
    end

    // Transitions T_SELECT, T_LAUNCH, T_FINISH.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNARMED: if (sel_load) state_d = ST_ARMED;
            ST_ARMED:   if (launch)   state_d = ST_HASHING;
            ST_HASHING: if (finish)   state_d = ST_UNARMED;
            default:                  state_d = ST_UNARMED;
        endcase
    end

    // State-decoded outputs.
    always_comb begin
        armed = 1'b0;
        busy  = 1'b0;
        unique case (state_q)
            ST_UNARMED: ;
            ST_ARMED:   armed = 1'b1;
            ST_HASHING: busy  = 1'b1;
            default:    ;
        endcase
    end

    // Settling counter, engine strobes and response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q          <= '0;
            hash_seed_load <= 1'b0;
            hash_start     <= 1'b0;
            hash_chal      <= '0;
            code_q         <= '0;
            code_valid     <= 1'b0;
        end else begin
            hash_seed_load <= sel_load;
            hash_start     <= launch;
            if (launch) begin
                cnt_q      <= CNT_LOAD;
                hash_chal  <= chal_data;
                code_valid <= 1'b0;
            end else if ((state_q == ST_HASHING) && (cnt_q != '0)) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
            if (finish) begin
                code_q     <= hash_code;
                code_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/auth_ctrl.sv
module auth_ctrl
    import auth_pkg::*;
#(
    parameter int BTD_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               hash_seed_load,
    output logic [KEY_W-1:0]   hash_func_key,
    output logic [KEY_W-1:0]   hash_seed_key,
    output logic               hash_start,
    output logic [KEY_W-1:0]   hash_chal,
    input  logic               hash_done,
    input  logic [CODE_W-1:0]  hash_code
);
    logic                            key_wr_en;
    logic [IDX_W-1:0]                key_wr_slot;
    logic [NUM_SLOTS-1:0]            lock_set;
    logic                            sel_load;
    logic [IDX_W-1:0]                sel_func;
    logic [IDX_W-1:0]                sel_seed;
    logic                            chal_load;
    logic                            err_q;
    logic [NUM_SLOTS-1:0][KEY_W-1:0] slot_q;
    logic [NUM_SLOTS-1:0]            lock_q;
    logic [IDX_W-1:0]                func_idx_q;
    logic [IDX_W-1:0]                seed_idx_q;
    logic                            armed;
    logic                            busy;
    logic [CODE_W-1:0]               code_q;
    logic                            code_valid;

    auth_bus_decode u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .lock_q     (lock_q),
        .slot_q     (slot_q),
        .func_idx_q (func_idx_q),
        .seed_idx_q (seed_idx_q),
        .armed      (armed),
        .busy       (busy),
        .code_valid (code_valid),
        .code_q     (code_q),
        .key_wr_en  (key_wr_en),
        .key_wr_slot(key_wr_slot),
        .lock_set   (lock_set),
        .sel_load   (sel_load),
        .sel_func   (sel_func),
        .sel_seed   (sel_seed),
        .chal_load  (chal_load),
        .err_q      (err_q),
        .bus_rdata  (bus_rdata)
    );

    auth_key_store u_keys (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (key_wr_en),
        .wr_slot    (key_wr_slot),
        .wr_data    (bus_wdata),
        .lock_set   (lock_set),
        .sel_load   (sel_load),
        .sel_func   (sel_func),
        .sel_seed   (sel_seed),
        .slot_q     (slot_q),
        .lock_q     (lock_q),
        .func_idx_q (func_idx_q),
        .seed_idx_q (seed_idx_q),
        .func_key   (hash_func_key),
        .seed_key   (hash_seed_key)
    );

    auth_seq_fsm #(.BTD_CYCLES(BTD_CYCLES)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel_load      (sel_load),
        .chal_load     (chal_load),
        .chal_data     (bus_wdata),
        .hash_done     (hash_done),
        .hash_code     (hash_code),
        .armed         (armed),
        .busy          (busy),
        .hash_seed_load(hash_seed_load),
        .hash_start    (hash_start),
        .hash_chal     (hash_chal),
        .code_q        (code_q),
        .code_valid    (code_valid)
    );
endmodule

// File: rtl/auth_ctrl_chk.sv
module auth_ctrl_chk
    import auth_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic                 hash_seed_load,
    input logic                 hash_start,
    input logic                 hash_done,
    input logic [NUM_SLOTS-1:0] lock_q,
    input logic                 err_q,
    input logic                 armed,
    input logic                 busy,
    input logic                 code_valid
);
    assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(bus_wr && (bus_addr == ADDR_W'(REG_STAT)) && bus_wdata[STAT_ERR])) |=> err_q);

    assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hash_start |-> busy);

    assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hash_start |=> !hash_start);

    assert_unarmed_chal_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_W'(REG_CHAL)) && !armed) |=> err_q);

    assert_no_reload_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        hash_seed_load |-> !busy);

    assert_valid_needs_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_valid) |-> $past(hash_done));

    assert_valid_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_valid) |-> ($past(busy) && !busy));
endmodule

bind auth_ctrl auth_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .hash_seed_load(hash_seed_load),
    .hash_start    (hash_start),
    .hash_done     (hash_done),
    .lock_q        (lock_q),
    .err_q         (err_q),
    .armed         (armed),
    .busy          (busy),
    .code_valid    (code_valid)
);

// File: tb/auth_ctrl_tb_top.sv
`timescale 1ns/1ps
module auth_ctrl_tb_top;
    localparam int BTD = 4;
    localparam logic [2:0] A_LOCK = 3'd0, A_SEL = 3'd4, A_CHAL = 3'd5, A_CODE = 3'd6, A_STAT = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        hash_seed_load;
    logic [31:0] hash_func_key;
    logic [31:0] hash_seed_key;
    logic        hash_start;
    logic [31:0] hash_chal;
    logic        hash_done;
    logic [7:0]  hash_code;
    logic        done_en = 1'b1;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [31:0] keys [3];
    logic [7:0]  last_code = '0;

    always #4 clk = ~clk;

    function automatic logic [7:0] engine_fn(logic [31:0] f, logic [31:0] s, logic [31:0] c);
        logic [31:0] x;
        x = f ^ {s[26:0], s[31:27]} ^ c;
        return x[7:0] ^ x[15:8] ^ x[23:16] ^ x[31:24];
    endfunction

    // Behavioural engine model driven by the controller's engine outputs.
    assign hash_code = engine_fn(hash_func_key, hash_seed_key, hash_chal);
    assign hash_done = done_en;

    auth_ctrl #(.BTD_CYCLES(BTD)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hash_seed_load(hash_seed_load), .hash_func_key(hash_func_key),
        .hash_seed_key(hash_seed_key), .hash_start(hash_start),
        .hash_chal(hash_chal), .hash_done(hash_done), .hash_code(hash_code)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bwrite(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic clear_err();
        logic [31:0] s;
        bwrite(A_STAT, 32'h1);
        peek(A_STAT, s);
        chk("R12 error cleared by writing 1", 32'(s[0]), 32'h0);
    endtask

    task automatic run_hash(int f, int s, logic [31:0] c, string tag);
        logic [31:0] v;
        bwrite(A_SEL, 32'((s << 2) | f));
        bwrite(A_CHAL, c);
        repeat (BTD) @(negedge clk);
        peek(A_CODE, v);
        last_code = engine_fn(keys[f], keys[s], c);
        chk(tag, v, 32'(last_code));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        peek(A_LOCK, v); chk("R1 lock reset", v, 0);
        peek(A_SEL, v);  chk("R1 selection reset", v, 0);
        peek(A_CODE, v); chk("R1 response reset", v, 0);
        peek(A_STAT, v); chk("R1 status reset", v, 0);
        chk("R1 strobes low", 32'({hash_start, hash_seed_load}), 0);
    endtask

    task automatic t_key_rw();
        logic [31:0] v;
        for (int i = 0; i < 3; i++) begin
            bwrite(3'(i + 1), keys[i]);
        end
        for (int i = 0; i < 3; i++) begin
            bread(3'(i + 1), v);
            chk("R2 key readback", v, keys[i]);
        end
    endtask

    task automatic t_select();
        bwrite(A_SEL, 32'((2 << 2) | 1));
        chk("R6 seed reload pulse", 32'(hash_seed_load), 1);
        chk("R6 function key", hash_func_key, keys[1]);
        chk("R6 seed key", hash_seed_key, keys[2]);
        @(negedge clk);
        chk("R6 reload is one cycle", 32'(hash_seed_load), 0);
    endtask

    task automatic t_timing();
        logic [31:0] v;
        logic [31:0] c;
        c = 32'hA5C3_1E77;
        bwrite(A_SEL, 32'((1 << 2) | 0));
        bwrite(A_CHAL, c);
        chk("R8 start pulse", 32'(hash_start), 1);
        chk("R8 challenge presented", hash_chal, c);
        peek(A_STAT, v);
        chk("R8 busy set", 32'(v[1]), 1);
        repeat (BTD - 1) @(negedge clk);
        chk("R8 start single cycle", 32'(hash_start), 0);
        peek(A_STAT, v);
        chk("R9 not valid before settling", 32'(v[2:1]), 32'b01);
        peek(A_CODE, v);
        chk("R9 previous response held", v, 32'(last_code));
        @(negedge clk);
        peek(A_STAT, v);
        chk("R9 valid set and busy clear", 32'(v[2:1]), 32'b10);
        peek(A_CODE, v);
        last_code = engine_fn(keys[0], keys[1], c);
        chk("R9 response value", v, 32'(last_code));
    endtask

    task automatic t_done_wait();
        logic [31:0] v;
        logic [31:0] c;
        c = 32'h0BAD_F00D;
        done_en = 1'b0;
        bwrite(A_SEL, 32'((0 << 2) | 2));
        bwrite(A_CHAL, c);
        repeat (BTD + 3) @(negedge clk);
        peek(A_STAT, v);
        chk("R10 still busy while engine not done", 32'(v[2:1]), 32'b01);
        done_en = 1'b1;
        @(negedge clk);
        peek(A_STAT, v);
        chk("R10 valid one edge after done", 32'(v[2:1]), 32'b10);
        peek(A_CODE, v);
        last_code = engine_fn(keys[2], keys[0], c);
        chk("R10 response value", v, 32'(last_code));
    endtask

    task automatic t_repeat_reject();
        logic [31:0] v;
        bwrite(A_CHAL, 32'h1234_5678);
        chk("R11 no start on repeat", 32'(hash_start), 0);
        peek(A_STAT, v);
        chk("R11 error set and not busy", 32'({v[1], v[0]}), 32'b01);
        repeat (BTD + 1) @(negedge clk);
        peek(A_CODE, v);
        chk("R11 response unchanged", v, 32'(last_code));
        clear_err();
    endtask

    task automatic t_bad_index();
        logic [31:0] v;
        bwrite(A_SEL, 32'((0 << 2) | 3));
        chk("R7 no reload on bad index", 32'(hash_seed_load), 0);
        peek(A_STAT, v);
        chk("R7 error set, not armed", 32'({v[3], v[0]}), 32'b01);
        bwrite(A_CHAL, 32'h1);
        peek(A_STAT, v);
        chk("R7 challenge refused after bad index", 32'(v[1]), 0);
        clear_err();
        bwrite(A_SEL, 32'((3 << 2) | 0));
        peek(A_STAT, v);
        chk("R7 seed index 3 refused", 32'({v[3], v[0]}), 32'b01);
        clear_err();
    endtask

    task automatic t_busy_select();
        logic [31:0] v;
        logic [31:0] c;
        c = 32'h5555_AAAA;
        bwrite(A_SEL, 32'h0);
        bwrite(A_CHAL, c);
        bwrite(A_SEL, 32'((2 << 2) | 1));
        chk("R13 no reload while busy", 32'(hash_seed_load), 0);
        peek(A_STAT, v);
        chk("R13 error set", 32'(v[0]), 1);
        peek(A_SEL, v);
        chk("R13 selection unchanged", v, 0);
        repeat (BTD) @(negedge clk);
        peek(A_CODE, v);
        last_code = engine_fn(keys[0], keys[0], c);
        chk("R6 same slot for both roles", v, 32'(last_code));
    endtask

    task automatic t_err_clear();
        logic [31:0] v;
        bwrite(A_STAT, 32'h0);
        peek(A_STAT, v);
        chk("R12 writing 0 keeps error", 32'(v[0]), 1);
        clear_err();
    endtask

    task automatic t_lock();
        logic [31:0] v;
        bwrite(A_LOCK, 32'b010);
        peek(A_LOCK, v);
        chk("R3 lock bit set", v, 32'b010);
        bread(3'd2, v);
        chk("R4 locked read returns zero", v, 0);
        peek(A_STAT, v);
        chk("R4 locked read sets error", 32'(v[0]), 1);
        clear_err();
        bwrite(3'd2, 32'hDEAD_0000);
        peek(A_STAT, v);
        chk("R4 locked write sets error", 32'(v[0]), 1);
        clear_err();
        run_hash(1, 1, 32'h7777_1111, "R5 locked key still used by engine, R4 write ignored");
        bread(3'd1, v);
        chk("R2 unlocked slot still readable", v, keys[0]);
        bwrite(A_LOCK, 32'h0);
        peek(A_LOCK, v);
        chk("R3 writing 0 does not unlock", v, 32'b010);
        bwrite(A_LOCK, 32'b001);
        peek(A_LOCK, v);
        chk("R3 lock bits accumulate", v, 32'b011);
    endtask

    initial begin
        keys[0] = 32'h1357_9BDF;
        keys[1] = 32'h2468_ACE0;
        keys[2] = 32'hC0FF_EE42;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_key_rw();
        t_select();
        t_timing();
        t_done_wait();
        t_repeat_reject();
        t_bad_index();
        t_busy_select();
        t_err_clear();
        t_lock();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule